// File: doc/BRIEF.md
# SMBus Register Target

This block is the device-side responder of an SMBus target. A bit-level front end, which is outside this block, turns SDA/SCL activity into a stream of single-cycle events: a start condition (plain or repeated), a stop condition, a received byte, a request for the next byte to transmit, and a report that the host answered the last transmitted byte with NACK. The responder decides whether to acknowledge each received byte. It keeps a register pointer and a transfer mode. It writes incoming data into an internal byte-wide register file, and it supplies the byte to send for each transmit request.

The first byte after the address is a command code. This code sets the register pointer and the transfer mode (byte, word or block). Both survive repeated starts and later transactions. A read that is not preceded by a command therefore returns data from the last selected register. Word and block transfers step through consecutive registers. A block read starts with a length byte that the device chooses: the effective length of the most recent block write.

Top module: `smbus_reg_target`

## Requirements
- R1: Event codes on `evt_kind_i` are 0 start/repeated start, 1 stop, 2 received byte, 3 transmit request and 4 host NACK. The first byte after a start is acknowledged only when bits [7:1] equal `DEV_ADDR`. Bit 0 selects read (1) or write (0). On a mismatch, that byte and every later byte are NACKed, and transmit requests are not served until the next start.
- R2: After a write address, the next byte is acknowledged as the command code. Bits [PW-1:0] become the register pointer and bits [7:6] the mode: 00 byte, 01 word, 10 block, 11 treated as byte.
- R3: Pointer and mode persist across repeated starts and later transactions. A read with no command returns data from the last selected register.
- R4: In byte mode, one data byte is acknowledged and written to the pointed register. Further data bytes are NACKed and change nothing.
- R5: In word mode, two data bytes are acknowledged and written to pointer and pointer+1, modulo `NUM_REGS`. A third byte is NACKed.
- R6: In block mode, the first data byte is a count and is acknowledged. The effective length is min(count, `MAX_BLK`). Exactly that many following bytes are acknowledged and written to consecutive registers; later bytes are NACKed.
- R7: A byte-mode read returns the pointed register, then 0xFF for any further request.
- R8: A word-mode read returns the pointed register (low byte) and then pointer+1 (high byte), then 0xFF.
- R9: A block-mode read returns the effective length of the last block write first, then that many consecutive registers, then 0xFF.
- R10: After a host NACK, no transmit request is served until the next start or stop.
- R11: `ack_valid_o` pulses exactly one cycle after each received-byte event, with the decision on `ack_o`. `tx_valid_o` pulses only one cycle after a served transmit request.
- R12: Reset clears all registers to 0, selects pointer 0 in byte mode, sets the block-read length to `BLK_RD_INIT` (4) and drives all outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_valid_i | input | 1 | Bus event present this cycle |
| evt_kind_i | input | 3 | Event code (see R1) |
| rx_data_i | input | 8 | Received byte, valid with a byte event |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid_o | output | 1 | Transmit byte valid for the served request |
| tx_data_o | output | 8 | Byte to transmit |

## Verification
The hardest situations to reach are the block-length boundaries. One is a count above the 32-byte cap, which needs 32 accepted data bytes before the first NACK. The other is a zero count, which must NACK the very next byte. The stimulus sends a count of 40 followed by 33 data bytes, then reads the block back to see the capped length byte. A separate transaction declares a count of zero. Pointer wrap from the last register to register 0 is reached with a word command on the top index. A mid-run reset followed by a bare read and a block read shows that the pointer, the mode and the block length have returned to their initial values.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [2:0] {
    EV_START = 3'd0,
    EV_STOP  = 3'd1,
    EV_BYTE  = 3'd2,
    EV_TXREQ = 3'd3,
    EV_HNACK = 3'd4
  } evt_e;

  typedef enum logic [1:0] {
    M_BYTE  = 2'b00,
    M_WORD  = 2'b01,
    M_BLOCK = 2'b10,
    M_BYTE2 = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RD, ST_HOLD
  } state_e;
endpackage

// File: rtl/smbt_regfile.sv
module smbt_regfile #(
  parameter int NUM_REGS = 64,
  localparam int PW = $clog2(NUM_REGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= 8'h00;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/smbt_ctrl.sv
module smbt_ctrl
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 64,
  parameter int         MAX_BLK     = 32,
  parameter int         BLK_RD_INIT = 4,
  localparam int        PW = $clog2(NUM_REGS),
  localparam int        LW = $clog2(MAX_BLK + 1),
  localparam int        CW = LW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_valid_i,
  input  evt_e          evt_kind_i,
  input  logic [7:0]    rx_data_i,
  output logic          we_o,
  output logic [PW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          ack_valid_o,
  output logic          ack_o,
  output logic [PW-1:0] base_o,
  output mode_e         mode_o,
  output logic [LW-1:0] blk_len_o,
  output logic          tx_en_o
);
  state_e        state_q, state_d;
  logic [PW-1:0] base_q, base_d;
  mode_e         mode_q, mode_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic [LW-1:0] blk_q, blk_d;
  logic          ack_d, ackv_q, ack_q;
  logic [LW-1:0] cnt_cap;

  assign cnt_cap = (rx_data_i > 8'(MAX_BLK)) ? LW'(MAX_BLK) : LW'(rx_data_i);

  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    mode_d  = mode_q;
    wcnt_d  = wcnt_q;
    blk_d   = blk_q;
    ack_d   = 1'b0;
    we_o    = 1'b0;
    waddr_o = base_q;
    if (evt_valid_i) begin
      case (evt_kind_i)
        EV_START: begin
          state_d = ST_ADDR;
          wcnt_d  = '0;
        end
        EV_STOP:  state_d = ST_IDLE;
        EV_HNACK: if (state_q == ST_RD) state_d = ST_HOLD;
        EV_BYTE: begin
          case (state_q)
            ST_ADDR: begin
              if (rx_data_i[7:1] == DEV_ADDR) begin
                ack_d   = 1'b1;
                state_d = rx_data_i[0] ? ST_RD : ST_CMD;
              end else begin
                state_d = ST_IDLE;
              end
            end
            ST_CMD: begin
              ack_d   = 1'b1;
              base_d  = rx_data_i[PW-1:0];
              mode_d  = mode_e'(rx_data_i[7:6]);
              state_d = ST_WDATA;
            end
            ST_WDATA: begin
              if (wcnt_q != '1) wcnt_d = wcnt_q + 1'b1;
              case (mode_q)
                M_WORD: begin
                  if (wcnt_q < CW'(2)) begin
                    ack_d   = 1'b1;
                    we_o    = 1'b1;
                    waddr_o = base_q + PW'(wcnt_q);
                  end
                end
                M_BLOCK: begin
                  if (wcnt_q == '0) begin
                    ack_d = 1'b1;
                    blk_d = cnt_cap;
                  end else if (wcnt_q <= CW'(blk_q)) begin
                    ack_d   = 1'b1;
                    we_o    = 1'b1;
                    waddr_o = base_q + PW'(wcnt_q - 1'b1);
                  end
                end
                default: begin
                  if (wcnt_q == '0) begin
                    ack_d = 1'b1;
                    we_o  = 1'b1;
                  end
                end
              endcase
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      mode_q  <= M_BYTE;
      wcnt_q  <= '0;
      blk_q   <= LW'(BLK_RD_INIT);
      ackv_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      mode_q  <= mode_d;
      wcnt_q  <= wcnt_d;
      blk_q   <= blk_d;
      ackv_q  <= evt_valid_i && (evt_kind_i == EV_BYTE);
      ack_q   <= ack_d;
    end
  end

  assign wdata_o     = rx_data_i;
  assign ack_valid_o = ackv_q;
  assign ack_o       = ack_q;
  assign base_o      = base_q;
  assign mode_o      = mode_q;
  assign blk_len_o   = blk_q;
  assign tx_en_o     = (state_q == ST_RD);
endmodule

// File: rtl/smbt_tx.sv
module smbt_tx
  import smbt_pkg::*;
#(
  parameter int  NUM_REGS = 64,
  parameter int  MAX_BLK  = 32,
  localparam int PW = $clog2(NUM_REGS),
  localparam int LW = $clog2(MAX_BLK + 1),
  localparam int CW = LW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_valid_i,
  input  evt_e          evt_kind_i,
  input  logic          tx_en_i,
  input  mode_e         mode_i,
  input  logic [PW-1:0] base_i,
  input  logic [LW-1:0] blk_len_i,
  input  logic [7:0]    rdata_i,
  output logic [PW-1:0] raddr_o,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o
);
  logic [CW-1:0] off_q;
  logic [7:0]    sel;
  logic          serve;
  logic          txv_q;
  logic [7:0]    txd_q;

  assign serve = evt_valid_i && (evt_kind_i == EV_TXREQ) && tx_en_i;

  always_comb begin
    case (mode_i)
      M_WORD: begin
        raddr_o = base_i + PW'(off_q);
        sel     = (off_q < CW'(2)) ? rdata_i : 8'hFF;
      end
      M_BLOCK: begin
        raddr_o = base_i + PW'(off_q - 1'b1);
        if (off_q == '0)                 sel = 8'(blk_len_i);
        else if (off_q <= CW'(blk_len_i)) sel = rdata_i;
        else                             sel = 8'hFF;
      end
      default: begin
        raddr_o = base_i;
        sel     = (off_q == '0) ? rdata_i : 8'hFF;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      txv_q <= 1'b0;
      txd_q <= 8'h00;
    end else begin
      txv_q <= serve;
      if (serve) begin
        txd_q <= sel;
        if (off_q != '1) off_q <= off_q + 1'b1;
      end
      if (evt_valid_i && evt_kind_i == EV_START) off_q <= '0;
    end
  end

  assign tx_valid_o = txv_q;
  assign tx_data_o  = txd_q;
endmodule

// File: rtl/smbus_reg_target.sv
module smbus_reg_target
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 64,
  parameter int         MAX_BLK     = 32,
  parameter int         BLK_RD_INIT = 4,
  localparam int        PW = $clog2(NUM_REGS),
  localparam int        LW = $clog2(MAX_BLK + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       evt_valid_i,
  input  logic [2:0] evt_kind_i,
  input  logic [7:0] rx_data_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o
);
  evt_e          kind;
  logic          we;
  logic [PW-1:0] waddr, raddr, base;
  logic [7:0]    wdata, rdata;
  mode_e         mode;
  logic [LW-1:0] blk_len;
  logic          tx_en;

  assign kind = evt_e'(evt_kind_i);

  smbt_ctrl #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS),
    .MAX_BLK(MAX_BLK), .BLK_RD_INIT(BLK_RD_INIT)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_kind_i(kind), .rx_data_i(rx_data_i),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .base_o(base), .mode_o(mode), .blk_len_o(blk_len), .tx_en_o(tx_en)
  );

  smbt_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  smbt_tx #(.NUM_REGS(NUM_REGS), .MAX_BLK(MAX_BLK)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_valid_i(evt_valid_i), .evt_kind_i(kind), .tx_en_i(tx_en),
    .mode_i(mode), .base_i(base), .blk_len_i(blk_len), .rdata_i(rdata),
    .raddr_o(raddr), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o)
  );
endmodule

// File: rtl/smbt_checker.sv
module smbt_checker
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       evt_valid_i,
  input logic [2:0] evt_kind_i,
  input logic [6:0] rx_addr_i,
  input logic       ack_valid_o,
  input logic       ack_o,
  input logic       tx_valid_o
);
  logic is_byte, is_req, is_start, is_stop;
  logic first_q, hn_q;

  assign is_byte  = evt_valid_i && (evt_kind_i == EV_BYTE);
  assign is_req   = evt_valid_i && (evt_kind_i == EV_TXREQ);
  assign is_start = evt_valid_i && (evt_kind_i == EV_START);
  assign is_stop  = evt_valid_i && (evt_kind_i == EV_STOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= 1'b0;
      hn_q    <= 1'b0;
    end else begin
      if (is_start)                first_q <= 1'b1;
      else if (is_byte || is_stop) first_q <= 1'b0;
      if (is_start || is_stop)                          hn_q <= 1'b0;
      else if (evt_valid_i && evt_kind_i == EV_HNACK)   hn_q <= 1'b1;
    end
  end

  a_r11_ack_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_byte |=> ack_valid_o);
  a_r11_no_stray_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_byte |=> !ack_valid_o);
  a_r11_ack_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_valid_o);
  a_r11_tx_only_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_req |=> !tx_valid_o);
  a_r10_quiet_after_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_req && hn_q) |=> !tx_valid_o);
  a_r1_foreign_addr_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_byte && first_q && rx_addr_i != DEV_ADDR) |=> !ack_o);
endmodule

bind smbus_reg_target smbt_checker #(.DEV_ADDR(DEV_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i),
  .evt_kind_i(evt_kind_i), .rx_addr_i(rx_data_i[7:1]),
  .ack_valid_o(ack_valid_o), .ack_o(ack_o), .tx_valid_o(tx_valid_o)
);

// File: tb/tb_smbus_reg_target.sv
module tb_smbus_reg_target;
  localparam logic [2:0] K_S = 3'd0, K_P = 3'd1, K_B = 3'd2, K_T = 3'd3, K_N = 3'd4;
  localparam logic [2:0] F0 = 3'b000, FA = 3'b110, FN = 3'b100, FT = 3'b001;
  localparam int NV = 63;
  // {req[3:0], kind[2:0], data[7:0], ackv/ack/txv, tx[7:0]}
  localparam logic [25:0] TBL [NV] = '{
    // R5 word write to reg 5, R1 address, R2 command
    {4'd5, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h54, FA, 8'h00},
    {4'd2, K_B, 8'h45, FA, 8'h00}, {4'd5, K_B, 8'h11, FA, 8'h00},
    {4'd5, K_B, 8'h22, FA, 8'h00}, {4'd5, K_B, 8'h33, FN, 8'h00},
    {4'd5, K_P, 8'h00, F0, 8'h00},
    // R3 bare read, R8 word order, R10 host NACK
    {4'd3, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h55, FA, 8'h00},
    {4'd8, K_T, 8'h00, FT, 8'h11}, {4'd8, K_T, 8'h00, FT, 8'h22},
    {4'd8, K_T, 8'h00, FT, 8'hFF}, {4'd10, K_N, 8'h00, F0, 8'h00},
    {4'd10, K_T, 8'h00, F0, 8'h00}, {4'd10, K_P, 8'h00, F0, 8'h00},
    // R4 byte write, R3 pointer across repeated start, R7 byte read
    {4'd4, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h54, FA, 8'h00},
    {4'd2, K_B, 8'h09, FA, 8'h00}, {4'd4, K_B, 8'hA5, FA, 8'h00},
    {4'd4, K_B, 8'h5A, FN, 8'h00}, {4'd3, K_S, 8'h00, F0, 8'h00},
    {4'd1, K_B, 8'h55, FA, 8'h00}, {4'd3, K_T, 8'h00, FT, 8'hA5},
    {4'd7, K_T, 8'h00, FT, 8'hFF}, {4'd10, K_N, 8'h00, F0, 8'h00},
    {4'd7, K_P, 8'h00, F0, 8'h00},
    // R6 block write of three bytes to reg 10
    {4'd6, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h54, FA, 8'h00},
    {4'd2, K_B, 8'h8A, FA, 8'h00}, {4'd6, K_B, 8'h03, FA, 8'h00},
    {4'd6, K_B, 8'hD1, FA, 8'h00}, {4'd6, K_B, 8'hD2, FA, 8'h00},
    {4'd6, K_B, 8'hD3, FA, 8'h00}, {4'd6, K_B, 8'hD4, FN, 8'h00},
    {4'd6, K_P, 8'h00, F0, 8'h00},
    // R9 block read with length byte
    {4'd9, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h54, FA, 8'h00},
    {4'd2, K_B, 8'h8A, FA, 8'h00}, {4'd9, K_S, 8'h00, F0, 8'h00},
    {4'd1, K_B, 8'h55, FA, 8'h00}, {4'd9, K_T, 8'h00, FT, 8'h03},
    {4'd9, K_T, 8'h00, FT, 8'hD1}, {4'd9, K_T, 8'h00, FT, 8'hD2},
    {4'd9, K_T, 8'h00, FT, 8'hD3}, {4'd9, K_T, 8'h00, FT, 8'hFF},
    {4'd10, K_N, 8'h00, F0, 8'h00}, {4'd9, K_P, 8'h00, F0, 8'h00},
    // R1 foreign address
    {4'd1, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h56, FN, 8'h00},
    {4'd1, K_B, 8'h00, FN, 8'h00}, {4'd1, K_T, 8'h00, F0, 8'h00},
    {4'd1, K_P, 8'h00, F0, 8'h00},
    // R5 word write wrapping from reg 63 to reg 0, read back (R8)
    {4'd5, K_S, 8'h00, F0, 8'h00}, {4'd1, K_B, 8'h54, FA, 8'h00},
    {4'd2, K_B, 8'h7F, FA, 8'h00}, {4'd5, K_B, 8'hC1, FA, 8'h00},
    {4'd5, K_B, 8'hC2, FA, 8'h00}, {4'd8, K_S, 8'h00, F0, 8'h00},
    {4'd1, K_B, 8'h55, FA, 8'h00}, {4'd8, K_T, 8'h00, FT, 8'hC1},
    {4'd8, K_T, 8'h00, FT, 8'hC2}, {4'd10, K_N, 8'h00, F0, 8'h00},
    {4'd8, K_P, 8'h00, F0, 8'h00}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       evt_valid_i = 1'b0;
  logic [2:0] evt_kind_i = 3'd0;
  logic [7:0] rx_data_i = 8'h00;
  logic       ack_valid_o, ack_o, tx_valid_o;
  logic [7:0] tx_data_o;
  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  smbus_reg_target dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i),
    .evt_kind_i(evt_kind_i), .rx_data_i(rx_data_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o)
  );

  task automatic check_out(string req, logic ev, logic ea, logic et, logic [7:0] ed);
    logic bad;
    checks++;
    bad = (ack_valid_o !== ev) || (tx_valid_o !== et) ||
          (ev && ack_o !== ea) || (et && tx_data_o !== ed);
    if (bad) begin
      errors++;
      $display("FAIL %s: got ackv=%0b ack=%0b txv=%0b tx=%02h, expected ackv=%0b ack=%0b txv=%0b tx=%02h",
               req, ack_valid_o, ack_o, tx_valid_o, tx_data_o, ev, ea, et, ed);
    end
  endtask

  task automatic ev(logic [2:0] k, logic [7:0] d);
    @(negedge clk_i);
    evt_valid_i = 1'b1;
    evt_kind_i  = k;
    rx_data_i   = d;
    @(negedge clk_i);
    evt_valid_i = 1'b0;
  endtask

  task automatic ev_chk(string req, logic [2:0] k, logic [7:0] d,
                        logic [2:0] f, logic [7:0] ed);
    ev(k, d);
    check_out(req, f[2], f[1], f[0], ed);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_out("R12", 1'b0, 1'b0, 1'b0, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_out("R12", 1'b0, 1'b0, 1'b0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = TBL[i];
      ev(v[21:19], v[18:11]);
      check_out($sformatf("R%0d step %0d", v[25:22], i), v[10], v[9], v[8], v[7:0]);
    end

    // R6 count above cap: 40 declared, only 32 accepted
    ev_chk("R6", K_S, 8'h00, F0, 8'h00);
    ev_chk("R6", K_B, 8'h54, FA, 8'h00);
    ev_chk("R6", K_B, 8'h80, FA, 8'h00);
    ev_chk("R6", K_B, 8'h28, FA, 8'h00);
    for (int i = 0; i < 32; i++) ev_chk("R6", K_B, 8'h60 + 8'(i), FA, 8'h00);
    ev_chk("R6", K_B, 8'hEE, FN, 8'h00);
    ev_chk("R6", K_P, 8'h00, F0, 8'h00);
    ev_chk("R9", K_S, 8'h00, F0, 8'h00);
    ev_chk("R9", K_B, 8'h55, FA, 8'h00);
    ev_chk("R9", K_T, 8'h00, FT, 8'h20);
    ev_chk("R9", K_T, 8'h00, FT, 8'h60);
    ev_chk("R9", K_T, 8'h00, FT, 8'h61);
    ev_chk("R10", K_N, 8'h00, F0, 8'h00);
    ev_chk("R10", K_T, 8'h00, F0, 8'h00);
    ev_chk("R9", K_P, 8'h00, F0, 8'h00);

    // R6 zero count: next byte refused
    ev_chk("R6", K_S, 8'h00, F0, 8'h00);
    ev_chk("R6", K_B, 8'h54, FA, 8'h00);
    ev_chk("R6", K_B, 8'h80, FA, 8'h00);
    ev_chk("R6", K_B, 8'h00, FA, 8'h00);
    ev_chk("R6", K_B, 8'h77, FN, 8'h00);
    ev_chk("R6", K_P, 8'h00, F0, 8'h00);
    ev_chk("R9", K_S, 8'h00, F0, 8'h00);
    ev_chk("R9", K_B, 8'h55, FA, 8'h00);
    ev_chk("R9", K_T, 8'h00, FT, 8'h00);
    ev_chk("R9", K_T, 8'h00, FT, 8'hFF);
    ev_chk("R9", K_P, 8'h00, F0, 8'h00);

    // R12 reset mid-run: registers, pointer, mode and block length restored
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check_out("R12", 1'b0, 1'b0, 1'b0, 8'h00);
    rst_ni = 1'b1;
    ev_chk("R12", K_S, 8'h00, F0, 8'h00);
    ev_chk("R12", K_B, 8'h55, FA, 8'h00);
    ev_chk("R12", K_T, 8'h00, FT, 8'h00);
    ev_chk("R12", K_T, 8'h00, FT, 8'hFF);
    ev_chk("R12", K_P, 8'h00, F0, 8'h00);
    ev_chk("R12", K_S, 8'h00, F0, 8'h00);
    ev_chk("R12", K_B, 8'h54, FA, 8'h00);
    ev_chk("R12", K_B, 8'h80, FA, 8'h00);
    ev_chk("R12", K_S, 8'h00, F0, 8'h00);
    ev_chk("R12", K_B, 8'h55, FA, 8'h00);
    ev_chk("R12", K_T, 8'h00, FT, 8'h04);
    ev_chk("R12", K_P, 8'h00, F0, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule